// File: doc/BRIEF.md
# SPI Slave Interface with Transmit and Receive Queues

This block is the target side of a four-wire SPI link, built to live on a synchronous register bus. The external master drives the serial clock, the active-low select and the MOSI line. The block samples all three with its own bus clock through a synchronizer, finds the serial clock edges in that domain, and moves one word per select frame. The polarity and phase inputs let it match whichever of the four clocking modes the master uses.

Words to send are queued by the bus side in a transmit queue. When a frame begins, the head of that queue is staged into the transmit shifter. If the queue is empty at that moment, the previously staged word goes out again. Each complete word shifted in from MOSI is appended to a receive queue, which the bus side drains one word per read strobe. The block reports the fill level of both queues, a receive-full flag and a sticky overflow flag. The serial clock must run slower than a quarter of the bus clock.

Top module: `spi_tgt_top`

## Requirements
- R1: After reset, both counts are 0, rx_full and rx_ovf are 0, and miso_o and miso_oe are 0.
- R2: A tx_wr_en pulse while tx_count is below TX_DEPTH adds tx_wr_data to the transmit queue, and tx_count rises by one on the next cycle. A write while tx_count equals TX_DEPTH is dropped, and the count stays.
- R3: rx_rd_data always shows the oldest received word, or 0 when rx_count is 0. An rx_rd_en pulse removes that word. A read of an empty queue changes nothing.
- R4: rx_full is 1 exactly while rx_count equals RX_DEPTH, and it clears once a read removes a word.
- R5: When WORD_W sample edges have occurred inside one frame with host_mode at 0, the word formed from MOSI, first bit as the most significant, is appended to the receive queue.
- R6: A word that completes while the receive queue is full is discarded, and rx_ovf sets. rx_ovf stays set until a read removes a word.
- R7: At the start of a frame (synchronized ss_n_i falling), the transmit queue head is popped into the shifter and tx_count falls by one. With an empty queue, the word staged for the previous frame is sent again, from its first bit.
- R8: cpol gives the idle level of sck_i. With cpha=0 the master samples on the leading edge; with cpha=1 it samples on the trailing edge. At each of its sample edges the master sees the next transmit bit on miso_o, starting with the most significant, and miso_oe is 1.
- R9: While ss_n_i is high, miso_o and miso_oe are 0 and sck_i and mosi_i activity adds nothing to the receive queue.
- R10: A frame that ends with fewer than WORD_W sample edges adds no word. The next frame starts at bit zero.
- R11: While host_mode is 1, the serial pins are ignored: no queue is popped or filled, and miso_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_mode | input | 1 | 1 disables the target function |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | 0: sample on leading edge, 1: on trailing edge |
| tx_wr_en | input | 1 | Push strobe for the transmit queue |
| tx_wr_data | input | WORD_W | Word to push |
| tx_count | output | clog2(TX_DEPTH+1) | Transmit queue fill level |
| rx_rd_en | input | 1 | Pop strobe for the receive queue |
| rx_rd_data | output | WORD_W | Oldest received word, 0 if empty |
| rx_count | output | clog2(RX_DEPTH+1) | Receive queue fill level |
| rx_full | output | 1 | Receive queue full |
| rx_ovf | output | 1 | Sticky receive overflow |
| sck_i | input | 1 | Serial clock from master |
| ss_n_i | input | 1 | Active-low select from master |
| mosi_i | input | 1 | Serial data from master |
| miso_o | output | 1 | Serial data to master |
| miso_oe | output | 1 | Output enable for miso_o |

## Verification
Bus-side effects are due one cycle after the strobe: a write or read shows in the counts on the next clock, and rx_rd_data follows at once. A change on a serial pin takes three bus cycles to act: two synchronizer stages, then the edge register. So a completed word, a frame-start pop and a new MISO bit appear three cycles after the pin moves. The bench holds every serial clock half-period for four bus cycles, samples MISO just before each sample edge, and waits six cycles after select rises before it compares the queue state. It compares its queue model against the ports on every clock while no frame is in flight.

// File: rtl/spi_tgt_pkg.sv
`timescale 1ns/1ps
package spi_tgt_pkg;

   typedef struct packed {
      logic lead;
      logic trail;
   } sck_edge_t;

   // Classify a change of the synchronized serial clock as leading or trailing,
   // given the idle level.
   function automatic sck_edge_t sck_edges(input logic prev, input logic now, input logic idle_hi);
      sck_edge_t e;
      logic rise, fall;
      rise    = now & ~prev;
      fall    = ~now & prev;
      e.lead  = idle_hi ? fall : rise;
      e.trail = idle_hi ? rise : fall;
      return e;
   endfunction

endpackage

// File: rtl/spi_tgt_sync.sv
`timescale 1ns/1ps
module spi_tgt_sync #(
   parameter int              WIDTH   = 3,
   parameter int              STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   initial assert (STAGES >= 2) else $error("spi_tgt_sync: STAGES must be at least 2");

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/spi_tgt_fifo.sv
`timescale 1ns/1ps
module spi_tgt_fifo #(
   parameter  int WIDTH = 8,
   parameter  int DEPTH = 8,
   localparam int AW    = $clog2(DEPTH),
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic [CW-1:0]    count,
   output logic             empty
);

   initial assert (DEPTH >= 2) else $error("spi_tgt_fifo: DEPTH must be at least 2");
   initial assert (WIDTH >= 1) else $error("spi_tgt_fifo: WIDTH must be positive");

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic             full, do_push, do_pop;

   // Pointer advance: free wrap for power-of-two depths, compare otherwise.
   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign do_pop  = pop & ~empty;
   assign do_push = push & (~full | do_pop);
   assign rdata   = empty ? '0 : mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/spi_tgt_shift.sv
`timescale 1ns/1ps
module spi_tgt_shift
   import spi_tgt_pkg::*;
#(
   parameter  int WIDTH = 8,
   localparam int BW    = $clog2(WIDTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             cpol,
   input  logic             cpha,
   input  logic             sck_s,
   input  logic             ss_n_s,
   input  logic             mosi_s,
   input  logic             tx_avail,
   input  logic [WIDTH-1:0] tx_word,
   output logic             tx_pop,
   output logic             rx_push,
   output logic [WIDTH-1:0] rx_word,
   output logic             miso,
   output logic             miso_oe
);

   initial assert (WIDTH >= 2) else $error("spi_tgt_shift: WIDTH must be at least 2");

   logic             sck_d, ss_n_d;
   logic [WIDTH-1:0] tx_hold, tx_shift;
   logic [WIDTH-2:0] rx_shift;
   logic [BW-1:0]    bit_cnt;
   logic             sel, frame_start, samp, drv, word_open;
   sck_edge_t        edg;

   assign sel         = enable & ~ss_n_s;
   assign frame_start = sel & ss_n_d;
   assign edg         = sck_edges(sck_d, sck_s, cpol);
   assign samp        = cpha ? edg.trail : edg.lead;
   assign drv         = cpha ? edg.lead  : edg.trail;
   assign word_open   = bit_cnt < BW'(WIDTH);

   assign tx_pop  = frame_start & tx_avail;
   assign rx_word = {rx_shift, mosi_s};
   assign rx_push = sel & ~frame_start & samp & (bit_cnt == BW'(WIDTH - 1));
   assign miso    = sel & tx_shift[WIDTH-1];
   assign miso_oe = sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d    <= 1'b0;
         ss_n_d   <= 1'b1;
         tx_hold  <= '0;
         tx_shift <= '0;
         rx_shift <= '0;
         bit_cnt  <= '0;
      end else begin
         sck_d  <= sck_s;
         ss_n_d <= ss_n_s;
         if (frame_start) begin
            // Stage a fresh word if one is queued, else replay the last one.
            tx_hold  <= tx_avail ? tx_word : tx_hold;
            tx_shift <= tx_avail ? tx_word : tx_hold;
            bit_cnt  <= '0;
         end else if (!sel) begin
            bit_cnt <= '0;
         end else begin
            if (samp && word_open) begin
               rx_shift <= rx_word[WIDTH-2:0];
               bit_cnt  <= bit_cnt + 1'b1;
            end
            // The first drive edge of a cpha=1 word presents the MSB already loaded.
            if (drv && word_open && bit_cnt != '0)
               tx_shift <= {tx_shift[WIDTH-2:0], 1'b0};
         end
      end
   end

endmodule

// File: rtl/spi_tgt_top.sv
`timescale 1ns/1ps
module spi_tgt_top #(
   parameter  int WORD_W      = 8,
   parameter  int TX_DEPTH    = 8,
   parameter  int RX_DEPTH    = 8,
   parameter  int SYNC_STAGES = 2,
   localparam int TCW         = $clog2(TX_DEPTH + 1),
   localparam int RCW         = $clog2(RX_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_mode,
   input  logic              cpol,
   input  logic              cpha,
   input  logic              tx_wr_en,
   input  logic [WORD_W-1:0] tx_wr_data,
   output logic [TCW-1:0]    tx_count,
   input  logic              rx_rd_en,
   output logic [WORD_W-1:0] rx_rd_data,
   output logic [RCW-1:0]    rx_count,
   output logic              rx_full,
   output logic              rx_ovf,
   input  logic              sck_i,
   input  logic              ss_n_i,
   input  logic              mosi_i,
   output logic              miso_o,
   output logic              miso_oe
);

   logic [2:0]        pins_s;
   logic              tx_empty, rx_empty, tx_pop, rx_push, rx_take;
   logic [WORD_W-1:0] tx_head, rx_word;

   spi_tgt_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({sck_i, ss_n_i, mosi_i}), .q(pins_s)
   );

   spi_tgt_shift #(.WIDTH(WORD_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .enable(~host_mode), .cpol(cpol), .cpha(cpha),
      .sck_s(pins_s[2]), .ss_n_s(pins_s[1]), .mosi_s(pins_s[0]),
      .tx_avail(~tx_empty), .tx_word(tx_head), .tx_pop(tx_pop),
      .rx_push(rx_push), .rx_word(rx_word), .miso(miso_o), .miso_oe(miso_oe)
   );

   spi_tgt_fifo #(.WIDTH(WORD_W), .DEPTH(TX_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .push(tx_wr_en), .wdata(tx_wr_data),
      .pop(tx_pop), .rdata(tx_head), .count(tx_count), .empty(tx_empty)
   );

   spi_tgt_fifo #(.WIDTH(WORD_W), .DEPTH(RX_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_word),
      .pop(rx_rd_en), .rdata(rx_rd_data), .count(rx_count), .empty(rx_empty)
   );

   assign rx_full = (rx_count == RCW'(RX_DEPTH));
   assign rx_take = rx_rd_en & ~rx_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             rx_ovf <= 1'b0;
      else if (rx_push && rx_full && !rx_take) rx_ovf <= 1'b1;
      else if (rx_take)                        rx_ovf <= 1'b0;
   end

endmodule

// File: rtl/spi_tgt_chk.sv
`timescale 1ns/1ps
module spi_tgt_chk #(
   parameter  int WORD_W   = 8,
   parameter  int TX_DEPTH = 8,
   parameter  int RX_DEPTH = 8,
   localparam int TCW      = $clog2(TX_DEPTH + 1),
   localparam int RCW      = $clog2(RX_DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_mode,
   input logic              tx_wr_en,
   input logic [TCW-1:0]    tx_count,
   input logic              rx_rd_en,
   input logic [WORD_W-1:0] rx_rd_data,
   input logic [RCW-1:0]    rx_count,
   input logic              rx_full,
   input logic              rx_ovf,
   input logic              ss_n_i,
   input logic              miso_o,
   input logic              miso_oe
);

   a_r2_tx_bound: assert property (@(posedge clk) disable iff (!rst_n)
      tx_count <= TCW'(TX_DEPTH));

   a_r2_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_count == TCW'(TX_DEPTH) && tx_wr_en) |=> tx_count <= $past(tx_count));

   a_r3_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_count == '0) |-> (rx_rd_data == '0));

   a_r3_read_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_rd_en && rx_count != '0) |=> rx_count <= $past(rx_count));

   a_r4_full_means_depth: assert property (@(posedge clk) disable iff (!rst_n)
      rx_full |-> (rx_count == RCW'(RX_DEPTH)));

   a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ovf && !rx_rd_en) |=> rx_ovf);

   a_r6_ovf_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_ovf) |-> $past(rx_full));

   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (ss_n_i && $past(ss_n_i) && $past(ss_n_i, 2)) |-> (!miso_oe && !miso_o));

   a_r11_host_released: assert property (@(posedge clk) disable iff (!rst_n)
      host_mode |-> !miso_oe);

endmodule

bind spi_tgt_top spi_tgt_chk #(.WORD_W(WORD_W), .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .tx_wr_en(tx_wr_en),
   .tx_count(tx_count), .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data),
   .rx_count(rx_count), .rx_full(rx_full), .rx_ovf(rx_ovf), .ss_n_i(ss_n_i),
   .miso_o(miso_o), .miso_oe(miso_oe)
);

// File: tb/sim_spi_tgt_top.sv
`timescale 1ns/1ps
module sim_spi_tgt_top;

   localparam int W = 8;
   localparam int D = 8;
   localparam int H = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_mode = 1'b0, cpol = 1'b0, cpha = 1'b0;
   logic       tx_wr_en = 1'b0, rx_rd_en = 1'b0;
   logic [7:0] tx_wr_data = '0;
   logic [3:0] tx_count, rx_count;
   logic [7:0] rx_rd_data;
   logic       rx_full, rx_ovf;
   logic       sck = 1'b0, ss_n = 1'b1, mosi = 1'b0;
   logic       miso, miso_oe;

   always #2.5 clk = ~clk;

   spi_tgt_top #(.WORD_W(W), .TX_DEPTH(D), .RX_DEPTH(D)) u0 (
      .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .cpol(cpol), .cpha(cpha),
      .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data), .tx_count(tx_count),
      .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data), .rx_count(rx_count),
      .rx_full(rx_full), .rx_ovf(rx_ovf), .sck_i(sck), .ss_n_i(ss_n),
      .mosi_i(mosi), .miso_o(miso), .miso_oe(miso_oe)
   );

   int checks = 0, errors = 0;
   bit done = 0, quiet = 0;
   logic [7:0] txq[$], rxq[$];
   logic [7:0] hold = '0;
   bit ovf_m = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Reference comparison on every clock while no frame is in flight.
   always @(posedge clk) begin
      #1;
      if (quiet && rst_n && !done) begin
         chk(int'(tx_count) == txq.size(), "R2 tx_count", int'(tx_count), txq.size());
         chk(int'(rx_count) == rxq.size(), "R5 rx_count", int'(rx_count), rxq.size());
         chk(rx_full == (rxq.size() == D), "R4 rx_full", int'(rx_full), int'(rxq.size() == D));
         chk(rx_ovf == ovf_m, "R6 rx_ovf", int'(rx_ovf), int'(ovf_m));
         chk(int'(rx_rd_data) == (rxq.size() > 0 ? int'(rxq[0]) : 0), "R3 rx_rd_data",
             int'(rx_rd_data), rxq.size() > 0 ? int'(rxq[0]) : 0);
      end
   end

   task automatic txw(input logic [7:0] d);
      tx_wr_en = 1'b1; tx_wr_data = d;
      if (txq.size() < D) txq.push_back(d);
      @(negedge clk);
      tx_wr_en = 1'b0;
   endtask

   task automatic rxr();
      int exp = rxq.size() > 0 ? int'(rxq[0]) : 0;
      chk(int'(rx_rd_data) == exp, "R3 read head", int'(rx_rd_data), exp);
      rx_rd_en = 1'b1;
      if (rxq.size() > 0) begin
         void'(rxq.pop_front());
         ovf_m = 0;
      end
      @(negedge clk);
      rx_rd_en = 1'b0;
   endtask

   task automatic set_mode(input logic p, input logic a);
      cpol = p; cpha = a; sck = p;
      repeat (4) @(negedge clk);
   endtask

   task automatic frame(input logic [7:0] mo, input int nbits);
      bit act = !host_mode;
      logic [7:0] exp_tx = hold;
      quiet = 0;
      if (act && txq.size() > 0) hold = txq.pop_front();
      exp_tx = hold;
      sck = cpol; ss_n = 1'b0;
      repeat (5) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         if (!cpha) begin
            mosi = mo[7-i];
            repeat (H) @(negedge clk);
         end else begin
            sck = ~cpol; mosi = mo[7-i];
            repeat (H) @(negedge clk);
         end
         if (act) begin
            chk(miso == exp_tx[7-i], "R8 miso bit", int'(miso), int'(exp_tx[7-i]));
            chk(miso_oe == 1'b1, "R8 miso_oe", int'(miso_oe), 1);
         end else begin
            chk(miso_oe == 1'b0 && miso == 1'b0, "R11 pins released", int'({miso_oe, miso}), 0);
         end
         if (!cpha) begin
            sck = ~cpol;
            repeat (H) @(negedge clk);
            sck = cpol;
         end else begin
            sck = cpol;
            repeat (H) @(negedge clk);
         end
      end
      repeat (H) @(negedge clk);
      ss_n = 1'b1;
      repeat (6) @(negedge clk);
      chk(miso_oe == 1'b0 && miso == 1'b0, "R9 idle miso", int'({miso_oe, miso}), 0);
      if (act && nbits == W) begin
         if (rxq.size() < D) rxq.push_back(mo);
         else ovf_m = 1;
      end
      quiet = 1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(tx_count == 0 && rx_count == 0, "R1 counts", int'({tx_count, rx_count}), 0);
      chk(!rx_full && !rx_ovf, "R1 flags", int'({rx_full, rx_ovf}), 0);
      chk(!miso_oe && !miso, "R1 miso", int'({miso_oe, miso}), 0);
      quiet = 1;

      // R2, R5, R7, R8 across all four clock modes
      txw(8'hA5); txw(8'h3C);
      set_mode(0, 0); frame(8'h96, W);
      set_mode(0, 1); frame(8'h0F, W);
      set_mode(1, 0); frame(8'hC1, W);   // R7 replay of 8'h3C
      set_mode(1, 1); frame(8'h7E, W);
      repeat (4) rxr();

      // R10 partial word dropped, then replay of the same staged word
      set_mode(0, 0);
      txw(8'h81);
      frame(8'hFF, 5);
      chk(rx_count == 0, "R10 partial dropped", int'(rx_count), 0);
      frame(8'h5A, W);
      rxr();

      // R4, R6 fill, overflow, recovery
      set_mode(0, 1);
      for (int k = 0; k < D; k++) frame(8'h10 + 8'(k), W);
      chk(rx_full == 1'b1, "R4 full at depth", int'(rx_full), 1);
      frame(8'hEE, W);
      chk(rx_ovf == 1'b1, "R6 overflow set", int'(rx_ovf), 1);
      rxr();
      chk(rx_ovf == 1'b0 && rx_full == 1'b0, "R6 R4 cleared by read", int'({rx_ovf, rx_full}), 0);
      while (rxq.size() > 0) rxr();

      // R2 write beyond depth dropped
      for (int k = 0; k < D + 1; k++) txw(8'hB0 + 8'(k));
      chk(int'(tx_count) == D, "R2 full write dropped", int'(tx_count), D);

      // R11 host mode ignores the serial side
      host_mode = 1'b1;
      repeat (2) @(negedge clk);
      frame(8'h33, W);
      chk(int'(tx_count) == D && rx_count == 0, "R11 queues untouched", int'(tx_count), D);
      host_mode = 1'b0;
      repeat (2) @(negedge clk);

      // R9 clock activity with select high
      for (int k = 0; k < 16; k++) begin
         sck = ~sck; mosi = ~mosi;
         repeat (H) @(negedge clk);
         chk(!miso_oe, "R9 oe while deselected", int'(miso_oe), 0);
      end
      sck = cpol;
      repeat (6) @(negedge clk);
      chk(rx_count == 0, "R9 no capture while deselected", int'(rx_count), 0);

      // R3 empty read leaves state
      rxr();
      chk(rx_count == 0 && rx_rd_data == 0, "R3 empty read", int'(rx_rd_data), 0);
      @(negedge clk);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule